// File: doc/BRIEF.md
# Strobed Input Port Handshake

This block is one 8-bit input port that takes in data from an external device under a strobe handshake. The device puts a byte on the port pins and pulses an active-low strobe. The block loads the pins into a holding latch while the strobe is low and raises a buffer-full flag. When the strobe returns high, the block raises an interrupt request, but only if its interrupt enable is set. The host reads the latched byte with an active-low read pulse. The start of the read withdraws the request and the end of the read clears the buffer-full flag.

The strobe and read inputs come from outside the clock domain. Each one passes through a chain of synchronising flops, and its edges are detected in the clock domain. The port pins are delayed by the same number of stages, so that the data stays aligned with the strobe. Each nanosecond limit on the pins therefore becomes a whole number of clock cycles.

The interrupt enable is written by single-bit set/reset commands. The port's three status flags are given as one field, ready to drop into bits 5..3 of a shared status register.

Top module: `strobed_input_port`

## Requirements
- R1: After reset, `data_out` is 0 and `buf_full`, `int_en` and `intr_req` are all 0.
- R2: With SYNC_STAGES=2, `buf_full` rises on the third rising clock edge after `strobe_n` falls.
- R3: After the strobe ends, `data_out` holds the pin value that was present while `strobe_n` was low. While `strobe_n` is high, a change on the pins does not alter `data_out`.
- R4: `intr_req` rises on the third rising clock edge after `strobe_n` rises, if `int_en` and `buf_full` are both 1. It never rises at any other time, and it stays 0 when `int_en` is 0.
- R5: `intr_req` returns to 0 on the third rising clock edge after `read_n` falls. This edge leaves `buf_full` unchanged.
- R6: `buf_full` returns to 0 on the third rising clock edge after `read_n` rises.
- R7: A cycle with `cmd_valid`=1 changes `int_en` only if `cmd_byte[7]`=0 and `cmd_byte[3:1]` equals EN_BIT (default 4). In that case `int_en` takes the value of `cmd_byte[0]` on the next edge. Any other command byte leaves `int_en` unchanged.
- R8: A new strobe that arrives while `buf_full` is 1 replaces the latched byte. `buf_full` stays 1 throughout.
- R9: `status_field` is {buf_full, int_en, intr_req}, with bit 2 being `buf_full`. These three bits go to bits 5, 4 and 3 of a shared status register.
- R10: When a strobe fall and a read rise are detected in the same cycle, the fall wins and `buf_full` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_pins | input | DATA_W | External data pins |
| strobe_n | input | 1 | Active-low load strobe, not synchronised to clk |
| read_n | input | 1 | Active-low host read, not synchronised to clk |
| cmd_valid | input | 1 | Single-bit command strobe, one cycle |
| cmd_byte | input | 8 | Single-bit set/reset command |
| data_out | output | DATA_W | Latched byte |
| buf_full | output | 1 | Latch holds data the host has not yet read |
| int_en | output | 1 | Interrupt enable |
| intr_req | output | 1 | Interrupt request |
| status_field | output | 3 | {buf_full, int_en, intr_req} |

## Verification
The bench builds the block with its defaults: DATA_W=8, SYNC_STAGES=2 and EN_BIT=4. With SYNC_STAGES=2, every handshake response lands on a fixed third clock edge. The bench can therefore sample just before and just after that edge, and confirm the exact latency of the flag, the request and both read edges. With EN_BIT=4, the bench can tell matching commands from commands for other bits. It can also drive a strobe fall in the same cycle as a read rise, which exercises the R10 priority. Random strobe, read and command traffic then checks that the flags and the latched byte follow a model written in the bench.

// File: rtl/strb_in_pkg.sv
package strb_in_pkg;

  // True when the command is a bit set/reset that addresses the enable bit.
  function automatic logic strb_cmd_hits(input logic [7:0] cmd, input logic [2:0] sel);
    return (cmd[7] == 1'b0) && (cmd[3:1] == sel);
  endfunction

  // Status layout: {full, enable, request}, placed at bits 5..3 of the shared register.
  function automatic logic [2:0] strb_pack_status(input logic full, input logic en,
                                                  input logic req);
    return {full, en, req};
  endfunction

endpackage

// File: rtl/sync_bit.sv
module sync_bit #(
  parameter int   STAGES   = 2,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= {STAGES{RST_VAL}};
    end else begin
      sh[0] <= d;
      for (int i = 1; i < STAGES; i++) sh[i] <= sh[i-1];
    end
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/edge_det.sv
module edge_det #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= IDLE;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/data_delay.sv
module data_delay #(
  parameter int DATA_W = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/hs_core.sv
module hs_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_low,
  input  logic              stb_fall,
  input  logic              stb_rise,
  input  logic              rd_fall,
  input  logic              rd_rise,
  input  logic              cmd_hit,
  input  logic              cmd_val,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] data_out,
  output logic              buf_full,
  output logic              int_en,
  output logic              intr_req
);
  logic req_set;
  assign req_set = stb_rise & int_en & buf_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_out <= '0;
      buf_full <= 1'b0;
      int_en   <= 1'b0;
      intr_req <= 1'b0;
    end else begin
      if (stb_low) data_out <= din;
      // A strobe fall takes priority over a read rise (R10).
      if (stb_fall)     buf_full <= 1'b1;
      else if (rd_rise) buf_full <= 1'b0;
      if (req_set)      intr_req <= 1'b1;
      else if (rd_fall) intr_req <= 1'b0;
      if (cmd_hit)      int_en   <= cmd_val;
    end
  end
endmodule

// File: rtl/strobed_input_port.sv
module strobed_input_port
  import strb_in_pkg::*;
#(
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [2:0] EN_BIT      = 3'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] port_pins,
  input  logic              strobe_n,
  input  logic              read_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_byte,
  output logic [DATA_W-1:0] data_out,
  output logic              buf_full,
  output logic              int_en,
  output logic              intr_req,
  output logic [2:0]        status_field
);
  // Synchronised strobe and read levels.
  logic stb_s, rd_s;
  // Named edge events, used by the core and the checker.
  logic stb_rise, stb_fall, rd_rise, rd_fall, cmd_hit;
  // Pin data delayed to line up with the strobe.
  logic [DATA_W-1:0] pins_d;

  sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_stb (
    .clk(clk), .rst_n(rst_n), .d(strobe_n), .q(stb_s));
  sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rd (
    .clk(clk), .rst_n(rst_n), .d(read_n), .q(rd_s));

  edge_det #(.IDLE(1'b1)) u_edge_stb (
    .clk(clk), .rst_n(rst_n), .lvl(stb_s), .rise(stb_rise), .fall(stb_fall));
  edge_det #(.IDLE(1'b1)) u_edge_rd (
    .clk(clk), .rst_n(rst_n), .lvl(rd_s), .rise(rd_rise), .fall(rd_fall));

  data_delay #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_delay (
    .clk(clk), .rst_n(rst_n), .d(port_pins), .q(pins_d));

  assign cmd_hit = cmd_valid & strb_cmd_hits(cmd_byte, EN_BIT);

  hs_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .stb_low(~stb_s), .stb_fall(stb_fall), .stb_rise(stb_rise),
    .rd_fall(rd_fall), .rd_rise(rd_rise),
    .cmd_hit(cmd_hit), .cmd_val(cmd_byte[0]),
    .din(pins_d), .data_out(data_out),
    .buf_full(buf_full), .int_en(int_en), .intr_req(intr_req));

  assign status_field = strb_pack_status(buf_full, int_en, intr_req);
endmodule

// File: rtl/strobed_input_port_chk.sv
module strobed_input_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stb_s,
  input logic              stb_fall,
  input logic              stb_rise,
  input logic              rd_fall,
  input logic              rd_rise,
  input logic              cmd_hit,
  input logic              cmd_val,
  input logic [DATA_W-1:0] data_out,
  input logic              buf_full,
  input logic              int_en,
  input logic              intr_req
);
  assert_full_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stb_fall |=> buf_full);

  assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stb_s |=> $stable(data_out));

  assert_intr_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rise && int_en && buf_full) |=> intr_req);

  assert_intr_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr_req) |-> $past(stb_rise));

  assert_intr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && !stb_rise) |=> !intr_req);

  assert_full_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && !stb_fall) |=> !buf_full);

  assert_en_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit |=> (int_en == $past(cmd_val)));

  assert_en_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_hit |=> $stable(int_en));

  assert_full_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && !rd_rise) |=> buf_full);
endmodule

bind strobed_input_port strobed_input_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stb_s(stb_s), .stb_fall(stb_fall), .stb_rise(stb_rise),
  .rd_fall(rd_fall), .rd_rise(rd_rise), .cmd_hit(cmd_hit), .cmd_val(cmd_byte[0]),
  .data_out(data_out), .buf_full(buf_full), .int_en(int_en), .intr_req(intr_req));

// File: tb/strobed_input_port_bench.sv
module strobed_input_port_bench;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] port_pins = '0;
  logic          strobe_n = 1'b1;
  logic          read_n = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [7:0]    cmd_byte = '0;
  logic [DW-1:0] data_out;
  logic          buf_full, int_en, intr_req;
  logic [2:0]    status_field;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Model state
  logic [DW-1:0] m_data;
  logic          m_full, m_en, m_intr;

  always #10 clk = ~clk;

  strobed_input_port u_strobed_input_port (
    .clk(clk), .rst_n(rst_n), .port_pins(port_pins), .strobe_n(strobe_n),
    .read_n(read_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .data_out(data_out), .buf_full(buf_full), .int_en(int_en),
    .intr_req(intr_req), .status_field(status_field));

  function automatic logic [2:0] exp_status(input logic f, input logic e, input logic r);
    exp_status = 3'b000;
    exp_status[2] = f;
    exp_status[1] = e;
    exp_status[0] = r;
  endfunction

  function automatic logic exp_en_after(input logic cur, input logic [7:0] c);
    if (!c[7] && c[3:1] == 3'd4) return c[0];
    return cur;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [7:0] c);
    cmd_byte = c; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    m_en = exp_en_after(m_en, c);
  endtask

  task automatic strobe_pulse(input logic [DW-1:0] d, input int width);
    port_pins = d;
    @(negedge clk);
    strobe_n = 1'b0;
    waitn(width);
    strobe_n = 1'b1;
    waitn(3);
    port_pins = ~d;
    waitn(2);
    m_data = d;
    m_full = 1'b1;
    if (m_en) m_intr = 1'b1;
  endtask

  task automatic read_pulse(input int width);
    read_n = 1'b0;
    waitn(width);
    read_n = 1'b1;
    waitn(4);
    m_intr = 1'b0;
    m_full = 1'b0;
  endtask

  task automatic check_model(input string tag);
    chk({tag, " data R3"}, data_out, m_data);
    chk({tag, " full R2"}, buf_full, m_full);
    chk({tag, " intr R4"}, intr_req, m_intr);
    chk({tag, " en R7"}, int_en, m_en);
    chk({tag, " status R9"}, status_field, exp_status(m_full, m_en, m_intr));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd1357);
    m_data = '0; m_full = 0; m_en = 0; m_intr = 0;
    waitn(3);
    // R1: reset state, while reset is still active
    chk("R1 data", data_out, 0);
    chk("R1 full", buf_full, 0);
    chk("R1 en", int_en, 0);
    chk("R1 intr", intr_req, 0);
    rst_n = 1'b1;
    waitn(2);
    chk("R9 status after reset", status_field, 0);

    // R2 latency and R3 capture, with the enable off
    port_pins = 8'hA5;
    @(negedge clk);
    strobe_n = 1'b0;
    waitn(2);
    chk("R2 full not yet at edge 2", buf_full, 0);
    waitn(1);
    chk("R2 full at edge 3", buf_full, 1);
    waitn(2);
    strobe_n = 1'b1;
    waitn(2);
    chk("R4 no intr edge 2", intr_req, 0);
    waitn(1);
    chk("R4 no intr when disabled", intr_req, 0);
    port_pins = 8'h5A;
    waitn(4);
    chk("R3 latched value kept", data_out, 8'hA5);
    m_data = 8'hA5; m_full = 1;

    // R5 then R6 timing
    read_n = 1'b0;
    waitn(3);
    chk("R5 full kept by read fall", buf_full, 1);
    waitn(1);
    read_n = 1'b1;
    waitn(2);
    chk("R6 full still set at edge 2", buf_full, 1);
    waitn(1);
    chk("R6 full cleared at edge 3", buf_full, 0);
    m_full = 0;

    // R7 commands
    send_cmd(8'h09);
    chk("R7 enable set", int_en, 1);
    send_cmd(8'h88);
    chk("R7 bit7=1 ignored", int_en, 1);
    send_cmd(8'h04);
    chk("R7 other bit ignored", int_en, 1);
    chk("R9 status enable only", status_field, 3'b010);

    // R4 request timing
    port_pins = 8'h3C;
    @(negedge clk);
    strobe_n = 1'b0;
    waitn(4);
    strobe_n = 1'b1;
    waitn(2);
    chk("R4 intr not yet at edge 2", intr_req, 0);
    waitn(1);
    chk("R4 intr at edge 3", intr_req, 1);
    chk("R9 status all set", status_field, 3'b111);
    waitn(2);

    // R8 overwrite while full
    port_pins = 8'hC3;
    @(negedge clk);
    strobe_n = 1'b0;
    waitn(3);
    chk("R8 full stays", buf_full, 1);
    waitn(2);
    strobe_n = 1'b1;
    waitn(5);
    chk("R8 new data", data_out, 8'hC3);
    chk("R8 full after", buf_full, 1);

    // R5 request cleared by the read fall
    read_n = 1'b0;
    waitn(2);
    chk("R5 intr kept at edge 2", intr_req, 1);
    waitn(1);
    chk("R5 intr cleared at edge 3", intr_req, 0);
    chk("R5 full unchanged", buf_full, 1);
    waitn(1);

    // R10: strobe fall in the same cycle as the read rise
    port_pins = 8'h77;
    read_n = 1'b1;
    strobe_n = 1'b0;
    waitn(6);
    chk("R10 strobe fall wins", buf_full, 1);
    strobe_n = 1'b1;
    waitn(5);
    chk("R10 data", data_out, 8'h77);
    m_data = 8'h77; m_full = 1; m_intr = 1;
    read_pulse(3);
    send_cmd(8'h08);
    check_model("directed end");

    // Random traffic
    for (int t = 0; t < 60; t++) begin
      logic [7:0] c;
      c = 8'($urandom);
      if ($urandom % 2 == 0) c = {4'b0000, 3'd4, c[0]};
      send_cmd(c);
      if ($urandom % 4 != 0) strobe_pulse(8'($urandom), 2 + int'($urandom % 5));
      check_model("rand strobe");
      if ($urandom % 2 == 0) begin
        read_pulse(2 + int'($urandom % 4));
        check_model("rand read");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule